// File: doc/BRIEF.md
# Indexed Register Access Port

This block is the host-facing register front end of a peripheral on a small synchronous parallel bus. A two-bit address picks one of four 8-bit direct locations: a pointer register, a data window, a status byte and a programmed-I/O (PIO) data port. The pointer selects which of 32 indirect 8-bit registers the data window reaches. The peripheral core sees the whole indirect bank on a flat output bus.

After reset the block is in a restricted compatibility mode. In this mode the top bit of the pointer is ignored, so only the lower sixteen indirect registers can be reached. Setting a mode bit that lives inside the bank itself, in indirect register 12, unlocks the upper sixteen. Three slots in the upper half are reserved.

The PIO port moves bytes between host and core without using the pointer. It has a 4-entry FIFO for each direction, and the status byte shows the state of both FIFOs.

Top module: `idxp_regport`

## Requirements
- R1: Direct address 0 is the pointer, 1 is the data window, 2 is status and 3 is the PIO port. A read strobe sampled on one clock edge puts its data on `rdata` after that edge, and `rdata` holds its value until the next read.
- R2: A write to direct address 0 stores `wdata[4:0]` as the pointer. A read of direct address 0 returns the pointer with bits 7:5 as zero.
- R3: A write to direct address 1 stores `wdata` into the indirect register the pointer selects. A later read of direct address 1 with the same pointer returns that value.
- R4: After reset every indirect register reads 0x00, the pointer is 0, compatibility mode is active and `ext_mode` is low.
- R5: In compatibility mode, pointer bit 4 is ignored, so pointer value 16+n reads and writes indirect register n.
- R6: Bit 6 of indirect register 12 selects extended mode, where pointer values 16 to 31 reach their own registers. Clearing the bit restores aliasing from the next access on, and `ext_mode` shows the bit.
- R7: Indirect slots 22, 27 and 29 always read 0x00, and writes to them are discarded.
- R8: In the status byte, bit 0 is set when the host-read FIFO holds data and bit 1 is set when the host-write FIFO has a free entry. Bits 7:2 read zero.
- R9: Writes to direct address 3 enter the host-write FIFO, which holds 4 bytes. The core drains the bytes in arrival order, and writes made while the FIFO is full are dropped.
- R10: Reads of direct address 3 pop the host-read FIFO in the order the core pushed the bytes. A read while that FIFO is empty returns 0x00.
- R11: A cycle with `cs` low, or with `rd` and `wr` both high, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, sampled each edge |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Direct register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| core_rx_valid | input | 1 | Core offers a byte for the host |
| core_rx_data | input | 8 | Byte offered by the core |
| core_rx_ready | output | 1 | Host-read FIFO has room |
| core_tx_valid | output | 1 | Host-write FIFO holds a byte |
| core_tx_data | output | 8 | Oldest byte from the host |
| core_tx_ready | input | 1 | Core takes the oldest byte |
| ext_mode | output | 1 | Extended mode active |
| regs_flat | output | 256 | Indirect bank, slot i at bits 8i+7:8i |

## Verification
The bench writes through pointer values 16 and above while the block is in compatibility mode. A design that kept bit 4 would leave register 5 untouched and return a stale value. It then sets and clears the mode bit and reads the same two pointers again, which catches a design that latches the mode or misses the return to aliasing. Reserved slots are written with 0xFF and read back, which exposes storage that should not exist. The PIO FIFO is overfilled and overdrained: a wrong full flag either accepts a fifth byte or corrupts the order, and a read of the empty FIFO must return zero instead of stale data. Strobes with `cs` low and with `rd` and `wr` both high are shown to leave the pointer unchanged.

// File: rtl/idxp_pkg.sv
package idxp_pkg;

   typedef enum logic [1:0] {
      DA_POINTER = 2'd0,
      DA_WINDOW  = 2'd1,
      DA_STATUS  = 2'd2,
      DA_PIO     = 2'd3
   } dir_addr_e;

   localparam int unsigned MODE_SLOT = 12;
   localparam int unsigned MODE_BIT  = 6;
   localparam logic [31:0] RSVD_MASK = 32'h2840_0000; // slots 22, 27, 29

   localparam int unsigned ST_RX_AVAIL = 0;
   localparam int unsigned ST_TX_SPACE = 1;

endpackage

// File: rtl/idxp_fifo.sv
module idxp_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("idxp_fifo: DEPTH must be a power of two of at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("idxp_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         push_ok, pop_ok;
   logic [AW:0]  cnt;

   assign empty   = (wp == rp);
   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rp[AW-1:0]];
   assign cnt     = wp - rp;

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wp[AW-1:0]] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH));

   assert_fifo_grow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && !pop_ok) |=> cnt == (AW+1)'($past(cnt) + 1'b1));

   assert_fifo_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !push_ok) |=> cnt == (AW+1)'($past(cnt) - 1'b1));

endmodule

// File: rtl/idxp_bank.sv
module idxp_bank #(
   parameter int unsigned REG_W  = 8,
   parameter int unsigned N_REGS = 32,
   parameter logic [N_REGS-1:0] RSVD = N_REGS'(idxp_pkg::RSVD_MASK)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(N_REGS)-1:0] ptr,
   input  logic                     wr_en,
   input  logic [REG_W-1:0]         wdata,
   output logic [REG_W-1:0]         rd_val,
   output logic                     ext_mode,
   output logic [N_REGS*REG_W-1:0]  flat
);
   localparam int unsigned IDX_W = $clog2(N_REGS);

   generate
      if (N_REGS < 4 || (N_REGS & (N_REGS - 1)) != 0) begin : g_bad_regs
         $error("idxp_bank: N_REGS must be a power of two of at least 4");
      end
      if (idxp_pkg::MODE_SLOT >= N_REGS / 2) begin : g_bad_mode_slot
         $error("idxp_bank: mode slot must sit in the compatibility half");
      end
      if (idxp_pkg::MODE_BIT >= REG_W) begin : g_bad_mode_bit
         $error("idxp_bank: mode bit outside register width");
      end
   endgenerate

   logic [REG_W-1:0] slot [N_REGS];
   logic [IDX_W-1:0] eff_idx;

   // compatibility mode drops the top pointer bit
   assign eff_idx = ext_mode ? ptr : {1'b0, ptr[IDX_W-2:0]};

   genvar gi;
   generate
      for (gi = 0; gi < N_REGS; gi++) begin : g_slot
         if (RSVD[gi]) begin : g_rsvd
            assign slot[gi] = '0;
         end else begin : g_store
            logic [REG_W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  q <= '0;
               end else if (wr_en && eff_idx == IDX_W'(gi)) begin
                  q <= wdata;
               end
            end
            assign slot[gi] = q;
         end
         assign flat[gi*REG_W +: REG_W] = slot[gi];
      end
   endgenerate

   assign ext_mode = slot[idxp_pkg::MODE_SLOT][idxp_pkg::MODE_BIT];
   assign rd_val   = slot[eff_idx];

   assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot[22] | slot[27] | slot[29]) == '0);

   assert_mode_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && eff_idx == IDX_W'(idxp_pkg::MODE_SLOT))
      |=> ext_mode == $past(wdata[idxp_pkg::MODE_BIT]));

   assert_compat_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && wr_en) |=> $stable(flat[N_REGS*REG_W-1 : (N_REGS/2)*REG_W]));

endmodule

// File: rtl/idxp_regport.sv
module idxp_regport #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned N_REGS     = 32,
   parameter int unsigned FIFO_DEPTH = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs,
   input  logic                    rd,
   input  logic                    wr,
   input  logic [1:0]              addr,
   input  logic [REG_W-1:0]        wdata,
   output logic [REG_W-1:0]        rdata,
   input  logic                    core_rx_valid,
   input  logic [REG_W-1:0]        core_rx_data,
   output logic                    core_rx_ready,
   output logic                    core_tx_valid,
   output logic [REG_W-1:0]        core_tx_data,
   input  logic                    core_tx_ready,
   output logic                    ext_mode,
   output logic [N_REGS*REG_W-1:0] regs_flat
);
   import idxp_pkg::*;

   localparam int unsigned IDX_W = $clog2(N_REGS);

   generate
      if (REG_W < 2 || IDX_W > REG_W) begin : g_bad_width
         $error("idxp_regport: REG_W too narrow for pointer and status");
      end
   endgenerate

   logic             rd_fire, wr_fire;
   dir_addr_e        sel;
   logic [IDX_W-1:0] ptr_q;
   logic [REG_W-1:0] bank_rd, rd_mux, status;
   logic             rx_empty, rx_full, tx_empty, tx_full;
   logic [REG_W-1:0] rx_head;

   assign rd_fire = cs && rd && !wr;
   assign wr_fire = cs && wr && !rd;
   assign sel     = dir_addr_e'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (wr_fire && sel == DA_POINTER) begin
         ptr_q <= wdata[IDX_W-1:0];
      end
   end

   idxp_bank #(.REG_W(REG_W), .N_REGS(N_REGS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr      (ptr_q),
      .wr_en    (wr_fire && sel == DA_WINDOW),
      .wdata    (wdata),
      .rd_val   (bank_rd),
      .ext_mode (ext_mode),
      .flat     (regs_flat)
   );

   // core -> host direction
   idxp_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (core_rx_valid),
      .push_data (core_rx_data),
      .pop       (rd_fire && sel == DA_PIO),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   // host -> core direction
   idxp_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_fire && sel == DA_PIO),
      .push_data (wdata),
      .pop       (core_tx_ready),
      .head      (core_tx_data),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   assign core_rx_ready = !rx_full;
   assign core_tx_valid = !tx_empty;

   always_comb begin
      status              = '0;
      status[ST_RX_AVAIL] = !rx_empty;
      status[ST_TX_SPACE] = !tx_full;
   end

   always_comb begin
      unique case (sel)
         DA_POINTER: rd_mux = REG_W'(ptr_q);
         DA_WINDOW:  rd_mux = bank_rd;
         DA_STATUS:  rd_mux = status;
         DA_PIO:     rd_mux = rx_empty ? '0 : rx_head;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_fire) begin
         rdata <= rd_mux;
      end
   end

   assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> $stable(rdata));

   assert_ptr_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && sel == DA_POINTER) |=> rdata == REG_W'($past(ptr_q)));

   assert_status_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && sel == DA_STATUS) |=> rdata[REG_W-1:2] == '0);

   assert_pio_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && sel == DA_PIO && rx_empty) |=> rdata == '0);

   assert_idle_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_fire |=> $stable(ptr_q));

endmodule

// File: tb/idxp_regport_tb.sv
module idxp_regport_tb;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         cs, rd, wr;
   logic [1:0]   addr;
   logic [7:0]   wdata;
   logic [7:0]   rdata;
   logic         core_rx_valid;
   logic [7:0]   core_rx_data;
   logic         core_rx_ready;
   logic         core_tx_valid;
   logic [7:0]   core_tx_data;
   logic         core_tx_ready;
   logic         ext_mode;
   logic [255:0] regs_flat;

   int total = 0;
   int bad   = 0;
   logic done = 1'b0;
   logic rd_seen;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;

   idxp_regport u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata),
      .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
      .core_rx_ready(core_rx_ready),
      .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data),
      .core_tx_ready(core_tx_ready),
      .ext_mode(ext_mode), .regs_flat(regs_flat)
   );

   // monitor: a read strobe taken at a rising edge is compared at the next falling edge
   always @(posedge clk) rd_seen <= rst_n && cs && rd && !wr;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R1: unexpected read data act=%02h exp=none", rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (rdata !== e) begin
               bad++;
               $display("FAIL %s: act=%02h exp=%02h", t, rdata, e);
            end
         end
      end
   end

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
      end
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic host_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      cs = 1'b1; rd = 1'b1; addr = a;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic ind_wr(input logic [7:0] idx, input logic [7:0] d);
      host_wr(2'd0, idx);
      host_wr(2'd1, d);
   endtask

   task automatic ind_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
      host_wr(2'd0, idx);
      host_rd(2'd1, exp, tag);
   endtask

   task automatic core_push(input logic [7:0] d);
      core_rx_valid = 1'b1; core_rx_data = d;
      @(negedge clk);
      core_rx_valid = 1'b0;
   endtask

   task automatic core_pop(input logic [7:0] exp, input string tag);
      check8({7'd0, core_tx_valid}, 8'h01, tag);
      check8(core_tx_data, exp, tag);
      core_tx_ready = 1'b1;
      @(negedge clk);
      core_tx_ready = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
      core_rx_valid = 1'b0; core_rx_data = '0; core_tx_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 / R8: reset state
      check8({7'd0, ext_mode}, 8'h00, "R4 ext_mode after reset");
      host_rd(2'd2, 8'h02, "R8 status after reset");
      host_rd(2'd0, 8'h00, "R4 pointer after reset");
      host_rd(2'd1, 8'h00, "R4 slot 0 after reset");
      ind_rd(8'd12, 8'h00, "R4 slot 12 after reset");

      // R2 / R3: pointer and window
      ind_wr(8'd3, 8'hA5);
      host_rd(2'd0, 8'h03, "R2 pointer readback");
      host_rd(2'd1, 8'hA5, "R3 window readback");
      host_wr(2'd0, 8'hE7);
      host_rd(2'd0, 8'h07, "R2 upper wdata bits dropped");
      // R1: rdata holds between reads
      repeat (3) @(negedge clk);
      check8(rdata, 8'h07, "R1 rdata holds while idle");

      // R5: aliasing in compatibility mode
      ind_wr(8'd5, 8'h3C);
      ind_rd(8'd21, 8'h3C, "R5 pointer 21 aliases slot 5");
      ind_wr(8'd21, 8'h77);
      ind_rd(8'd5, 8'h77, "R5 write via 21 lands in slot 5");

      // R6: extended mode
      ind_wr(8'd12, 8'h40);
      check8({7'd0, ext_mode}, 8'h01, "R6 ext_mode set");
      ind_wr(8'd21, 8'h99);
      ind_rd(8'd5, 8'h77, "R6 slot 5 untouched in extended mode");
      ind_rd(8'd21, 8'h99, "R6 slot 21 reachable");
      ind_rd(8'd12, 8'h40, "R6 mode register readback");

      // R7: reserved slots
      ind_wr(8'd22, 8'hFF);
      ind_rd(8'd22, 8'h00, "R7 slot 22 reads zero");
      ind_wr(8'd27, 8'hFF);
      ind_rd(8'd27, 8'h00, "R7 slot 27 reads zero");
      ind_wr(8'd29, 8'hFF);
      ind_rd(8'd29, 8'h00, "R7 slot 29 reads zero");
      ind_rd(8'd21, 8'h99, "R7 neighbour slot unchanged");

      // R6: clearing the bit restores aliasing
      ind_wr(8'd12, 8'h00);
      check8({7'd0, ext_mode}, 8'h00, "R6 ext_mode cleared");
      ind_rd(8'd21, 8'h77, "R6 pointer 21 aliases again");

      // R9: host-write FIFO
      for (int i = 0; i < 5; i++) host_wr(2'd3, 8'h10 + 8'(i));
      host_rd(2'd2, 8'h00, "R8 status with tx full");
      core_pop(8'h10, "R9 tx order 0");
      host_rd(2'd2, 8'h02, "R8 status with tx space");
      core_pop(8'h11, "R9 tx order 1");
      core_pop(8'h12, "R9 tx order 2");
      core_pop(8'h13, "R9 tx order 3");
      check8({7'd0, core_tx_valid}, 8'h00, "R9 fifth byte dropped");

      // R10: host-read FIFO
      host_rd(2'd3, 8'h00, "R10 empty read returns zero");
      core_push(8'hC1);
      core_push(8'hC2);
      host_rd(2'd2, 8'h03, "R8 status with rx data");
      host_rd(2'd3, 8'hC1, "R10 rx order 0");
      host_rd(2'd3, 8'hC2, "R10 rx order 1");
      host_rd(2'd3, 8'h00, "R10 drained read returns zero");

      // R11: deselected and conflicting strobes
      host_wr(2'd0, 8'd9);
      cs = 1'b0; wr = 1'b1; addr = 2'd0; wdata = 8'd4;
      @(negedge clk);
      wr = 1'b0;
      host_rd(2'd0, 8'd9, "R11 write with cs low ignored");
      cs = 1'b1; wr = 1'b1; rd = 1'b1; addr = 2'd0; wdata = 8'd6;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0; rd = 1'b0;
      host_rd(2'd0, 8'd9, "R11 rd and wr together ignored");

      repeat (3) @(negedge clk);
      check8(8'(exp_q.size()), 8'h00, "R1 every read answered");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule